// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block accepts byte writes from a simple write bus and runs an automatic erase of one block of a small on-chip byte array when it sees a two-write unlock sequence. The first write must carry the erase code 20h, and it may go to any address. The second write must carry the confirm code D0h. The block that the second write's address falls into is the one erased. The erase walks through the block one byte at a time and spends a fixed number of clock cycles on each byte, so the time it takes is exact and can be checked.

Software polls an 8-bit status word. Bit 7 is the ready flag and bit 5 is the erase-fail flag. Every block carries a protection input: a lock bit for each program-ROM block and a rewrite-disable bit for each of the four data blocks. A protected target turns the command away. An interrupt enable turns the return to ready into a one-cycle pulse. A suspend enable and a suspend request let software pause a running erase and resume it later.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the status word reads 80h and the interrupt output is 0. The array byte at address a holds a mod 256, and no byte of the default array equals FFh.
- R2: A write of 20h followed by the next write of D0h starts an erase. The target block is bus_addr_i divided by BLK_BYTES, taken from the address of the D0h write. Status bit 7 reads 0 from the cycle after the D0h write.
- R3: With no suspend and no protection change, status bit 7 stays 0 for exactly BLK_BYTES*CYC_PER_BYTE cycles and then returns to 1.
- R4: When the erase finishes, every byte of the target block reads FFh and every byte outside that block is unchanged.
- R5: An accepted erase clears status bit 5 to 0, and a clean completion leaves it at 0. Bit 5 never reads 1 while bit 7 reads 0.
- R6: If the write after 20h carries any value other than D0h, the sequence is dropped and nothing is erased. A D0h write that is not preceded by an armed 20h is ignored.
- R7: Blocks 0 to NUM_ROM_BLK-1 are program-ROM blocks, guarded by rom_lock_i[k]. Block NUM_ROM_BLK+j is guarded by df_wp_i[j] for j from 0 to 3. A command aimed at a guarded block, or at a block number of NUM_BLK or above, is rejected: status bit 5 becomes 1, bit 7 stays 1, and nothing is erased.
- R8: If the protection input of the running target becomes 1, the erase stops at the next edge. Status then reads A0h. Bytes already erased stay FFh and the rest of the block keeps its old contents.
- R9: While rdy_irq_en_i is 1, rdy_irq_o pulses high for one cycle, and only in the cycle in which bit 7 rises because of a completion, an abort or a suspend. While rdy_irq_en_i is 0 it never pulses.
- R10: With susp_en_i at 1, holding susp_req_i at 1 during an erase pauses it at the next edge. That edge erases nothing, and bit 7 reads 1 while the erase is paused. With susp_en_i at 0 the request has no effect.
- R11: When susp_req_i returns to 0, bit 7 reads 0 again from the next cycle and the erase continues from the byte and cycle where it stopped.
- R12: Bus writes made while an erase is running or paused are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | AW | Write address |
| bus_data_i | input | 8 | Write data (command code) |
| rom_lock_i | input | NUM_ROM_BLK | Lock bit for each program-ROM block |
| df_wp_i | input | 4 | Rewrite-disable bit for each data block |
| rdy_irq_en_i | input | 1 | Ready interrupt enable |
| susp_en_i | input | 1 | Suspend enable |
| susp_req_i | input | 1 | Suspend request, level |
| rd_addr_i | input | AW | Array read address |
| rd_data_o | output | 8 | Array read data, combinational |
| status_o | output | 8 | Bit 7 ready, bit 5 erase fail, other bits 0 |
| rdy_irq_o | output | 1 | Ready interrupt pulse |

## Verification
The bench builds the block with two program-ROM blocks, blocks of 8 bytes and 2 cycles per byte, which gives six blocks, 48 bytes and a 16-cycle erase. At these sizes a suspend or an abort can be placed on the first byte, in the middle or near the end of a block in only a few cycles. The array is small enough to compare every byte against the model after each scenario. The sizes also keep the out-of-range block numbers 6 and 7 reachable, so the rejection of a block number past the last block is exercised.

// File: rtl/fes_pkg.sv
package fes_pkg;
    localparam logic [7:0] CODE_ERASE   = 8'h20;
    localparam logic [7:0] CODE_CONFIRM = 8'hD0;
    localparam int         STAT_READY   = 7;
    localparam int         STAT_FAIL    = 5;

    typedef enum logic [1:0] {
        ES_IDLE = 2'd0,
        ES_RUN  = 2'd1,
        ES_HOLD = 2'd2
    } es_state_e;
endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode #(
    parameter int NUM_BLK = 8,
    parameter int AW      = 7,
    parameter int OFF_W   = 4,
    localparam int BLK_W  = AW - OFF_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             idle_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [7:0]       data_i,
    input  logic [NUM_BLK-1:0] prot_i,
    output logic             start_o,
    output logic             reject_o,
    output logic [BLK_W-1:0] blk_o
);
    import fes_pkg::*;

    typedef struct packed {
        logic armed;
    } dec_t;

    dec_t dec_d, dec_q;
    logic guarded;

    assign blk_o = addr_i[AW-1:OFF_W];

    always_comb begin
        guarded = 1'b1;
        if (32'(blk_o) < NUM_BLK) begin
            guarded = prot_i[blk_o];
        end
    end

    always_comb begin
        dec_d    = dec_q;
        start_o  = 1'b0;
        reject_o = 1'b0;
        if (!idle_i) begin
            dec_d.armed = 1'b0;
        end else if (wr_i) begin
            if (dec_q.armed) begin
                dec_d.armed = 1'b0;
                if (data_i == CODE_CONFIRM) begin
                    start_o  = !guarded;
                    reject_o = guarded;
                end
            end else if (data_i == CODE_ERASE) begin
                dec_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end
endmodule

// File: rtl/fes_array.sv
module fes_array #(
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'(i);
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= 8'hFF;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        if (32'(raddr_i) < DEPTH) begin
            rdata_o = mem_q[raddr_i];
        end
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
    parameter int NUM_ROM_BLK  = 4,
    parameter int BLK_BYTES    = 16,
    parameter int CYC_PER_BYTE = 3,
    localparam int NUM_BLK     = NUM_ROM_BLK + 4,
    localparam int DEPTH       = NUM_BLK * BLK_BYTES,
    localparam int AW          = $clog2(DEPTH),
    localparam int OFF_W       = $clog2(BLK_BYTES),
    localparam int BLK_W       = AW - OFF_W,
    localparam int CYC_W       = (CYC_PER_BYTE > 1) ? $clog2(CYC_PER_BYTE) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   bus_wr_i,
    input  logic [AW-1:0]          bus_addr_i,
    input  logic [7:0]             bus_data_i,
    input  logic [NUM_ROM_BLK-1:0] rom_lock_i,
    input  logic [3:0]             df_wp_i,
    input  logic                   rdy_irq_en_i,
    input  logic                   susp_en_i,
    input  logic                   susp_req_i,
    input  logic [AW-1:0]          rd_addr_i,
    output logic [7:0]             rd_data_o,
    output logic [7:0]             status_o,
    output logic                   rdy_irq_o
);
    import fes_pkg::*;

    typedef struct packed {
        es_state_e        st;
        logic [BLK_W-1:0] blk;
        logic [OFF_W-1:0] idx;
        logic [CYC_W-1:0] cyc;
        logic             ready;
        logic             fail;
        logic             irq;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [NUM_BLK-1:0] prot;
    logic               start, reject;
    logic [BLK_W-1:0]   cmd_blk;
    logic               byte_we;

    assign prot = {df_wp_i, rom_lock_i};

    fes_cmd_decode #(
        .NUM_BLK (NUM_BLK),
        .AW      (AW),
        .OFF_W   (OFF_W)
    ) u_dec (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .idle_i   (eng_q.st == ES_IDLE),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .data_i   (bus_data_i),
        .prot_i   (prot),
        .start_o  (start),
        .reject_o (reject),
        .blk_o    (cmd_blk)
    );

    fes_array #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_arr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (byte_we),
        .waddr_i ({eng_q.blk, eng_q.idx}),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    always_comb begin
        eng_d     = eng_q;
        eng_d.irq = 1'b0;
        byte_we   = 1'b0;
        unique case (eng_q.st)
            ES_IDLE: begin
                if (start) begin
                    eng_d.st    = ES_RUN;
                    eng_d.blk   = cmd_blk;
                    eng_d.idx   = '0;
                    eng_d.cyc   = '0;
                    eng_d.ready = 1'b0;
                    eng_d.fail  = 1'b0;
                end else if (reject) begin
                    eng_d.fail  = 1'b1;
                end
            end
            ES_RUN, ES_HOLD: begin
                if (prot[eng_q.blk]) begin
                    eng_d.st    = ES_IDLE;
                    eng_d.ready = 1'b1;
                    eng_d.fail  = 1'b1;
                    eng_d.irq   = rdy_irq_en_i && !eng_q.ready;
                end else if (eng_q.st == ES_HOLD) begin
                    if (!susp_req_i) begin
                        eng_d.st    = ES_RUN;
                        eng_d.ready = 1'b0;
                    end
                end else if (susp_en_i && susp_req_i) begin
                    eng_d.st    = ES_HOLD;
                    eng_d.ready = 1'b1;
                    eng_d.irq   = rdy_irq_en_i;
                end else if (eng_q.cyc == CYC_W'(CYC_PER_BYTE - 1)) begin
                    byte_we   = 1'b1;
                    eng_d.cyc = '0;
                    if (eng_q.idx == OFF_W'(BLK_BYTES - 1)) begin
                        eng_d.st    = ES_IDLE;
                        eng_d.ready = 1'b1;
                        eng_d.irq   = rdy_irq_en_i;
                    end else begin
                        eng_d.idx = eng_q.idx + 1'b1;
                    end
                end else begin
                    eng_d.cyc = eng_q.cyc + 1'b1;
                end
            end
            default: eng_d.st = ES_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            eng_q       <= '0;
            eng_q.st    <= ES_IDLE;
            eng_q.ready <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        status_o             = 8'h00;
        status_o[STAT_READY] = eng_q.ready;
        status_o[STAT_FAIL]  = eng_q.fail;
    end

    assign rdy_irq_o = eng_q.irq;
endmodule

// File: rtl/fes_checker.sv
module fes_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [7:0] status_o,
    input logic       rdy_irq_o,
    input logic       rdy_irq_en_i,
    input logic       susp_en_i,
    input logic       susp_req_i
);
    a_r9_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdy_irq_o |-> $past(rdy_irq_en_i));

    a_r9_irq_on_ready_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdy_irq_o |-> (status_o[7] && !$past(status_o[7])));

    a_r9_irq_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdy_irq_o |=> !rdy_irq_o);

    a_r5_no_fail_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !status_o[7] |-> !status_o[5]);

    a_r10_suspend_gives_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!status_o[7] && susp_en_i && susp_req_i) |=> status_o[7]);

    a_r1_unused_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & 8'h5F) == 8'h00);
endmodule

bind flash_erase_seq fes_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .status_o     (status_o),
    .rdy_irq_o    (rdy_irq_o),
    .rdy_irq_en_i (rdy_irq_en_i),
    .susp_en_i    (susp_en_i),
    .susp_req_i   (susp_req_i)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
    localparam int NR  = 2;
    localparam int BB  = 8;
    localparam int CPB = 2;
    localparam int NB  = NR + 4;
    localparam int DEP = NB * BB;
    localparam int AW  = $clog2(DEP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data = '0;
    logic [NR-1:0] lock = '0;
    logic [3:0]    wp = '0;
    logic          irq_en = 1'b0;
    logic          s_en = 1'b0;
    logic          s_req = 1'b0;
    logic [AW-1:0] raddr = '0;
    logic [7:0]    rdata;
    logic [7:0]    status;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    string cur = "R1";

    always #10 clk = ~clk;

    flash_erase_seq #(.NUM_ROM_BLK(NR), .BLK_BYTES(BB), .CYC_PER_BYTE(CPB)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_data_i(data), .rom_lock_i(lock), .df_wp_i(wp),
        .rdy_irq_en_i(irq_en), .susp_en_i(s_en), .susp_req_i(s_req),
        .rd_addr_i(raddr), .rd_data_o(rdata), .status_o(status), .rdy_irq_o(irq)
    );

    // behavioural reference model
    int  m_st = 0;
    int  m_blk = 0, m_idx = 0, m_cyc = 0;
    bit  m_ready = 1, m_fail = 0, m_irq = 0, m_armed = 0;
    int  m_mem [DEP];

    function automatic bit guarded(int b);
        if (b >= NB) return 1'b1;
        if (b < NR) return lock[b];
        return wp[b - NR];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ready = 1; m_fail = 0; m_irq = 0; m_armed = 0;
            for (int i = 0; i < DEP; i++) m_mem[i] = i % 256;
        end else begin
            int nst;
            bit nirq;
            nst = m_st; nirq = 0;
            if (m_st == 0) begin
                if (wr) begin
                    if (m_armed) begin
                        m_armed = 0;
                        if (data == 8'hD0) begin
                            int b;
                            b = int'(addr) / BB;
                            if (guarded(b)) m_fail = 1;
                            else begin
                                nst = 1; m_blk = b; m_idx = 0; m_cyc = 0;
                                m_ready = 0; m_fail = 0;
                            end
                        end
                    end else if (data == 8'h20) m_armed = 1;
                end
            end else begin
                m_armed = 0;
                if (guarded(m_blk)) begin
                    nst = 0; nirq = irq_en && !m_ready; m_ready = 1; m_fail = 1;
                end else if (m_st == 2) begin
                    if (!s_req) begin nst = 1; m_ready = 0; end
                end else if (s_en && s_req) begin
                    nst = 2; m_ready = 1; nirq = irq_en;
                end else begin
                    m_cyc++;
                    if (m_cyc == CPB) begin
                        m_cyc = 0;
                        m_mem[m_blk*BB + m_idx] = 8'hFF;
                        m_idx++;
                        if (m_idx == BB) begin nst = 0; m_ready = 1; nirq = irq_en; end
                    end
                end
            end
            m_st = nst; m_irq = nirq;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison of registered outputs
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] exp_st;
            exp_st = {m_ready, 1'b0, m_fail, 5'b0};
            check(status == exp_st, {cur, " status"}, status, exp_st);
            check(irq == m_irq, {cur, " R9 irq"}, irq, m_irq);
        end
    end

    task automatic bus_wr(int a, logic [7:0] d);
        @(negedge clk);
        addr = AW'(a); data = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic mem_cmp(string req);
        for (int i = 0; i < DEP; i++) begin
            raddr = AW'(i);
            #1;
            check(rdata == 8'(m_mem[i]), req, rdata, m_mem[i]);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    int busy;
    int irq_seen;

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(status == 8'h80, "R1 reset status", status, 8'h80);
        check(irq == 1'b0, "R1 reset irq", irq, 0);
        mem_cmp("R1 reset pattern");

        // R2 R3 R4 R5: clean erase of block 1, no interrupt
        cur = "R3";
        bus_wr(0, 8'h20);
        bus_wr(1*BB + 3, 8'hD0);
        busy = 0;
        while (status[7] == 1'b0 && busy < 1000) begin busy++; @(negedge clk); end
        check(busy == BB*CPB, "R3 busy length", busy, BB*CPB);
        check(status == 8'h80, "R5 clean status", status, 8'h80);
        mem_cmp("R4 block 1 erased");

        // R6: broken sequence and lone confirm
        cur = "R6";
        bus_wr(2*BB, 8'h20);
        bus_wr(2*BB, 8'h55);
        bus_wr(2*BB, 8'hD0);
        bus_wr(3*BB, 8'hD0);
        bus_wr(3*BB, 8'h20);
        bus_wr(3*BB, 8'h20);
        bus_wr(3*BB, 8'hD0);
        idle(3);
        check(status == 8'h80, "R6 still idle", status, 8'h80);
        mem_cmp("R6 nothing erased");

        // R7: locked ROM block, write-protected data block, out-of-range block
        cur = "R7";
        lock = 2'b01;
        bus_wr(0, 8'h20);
        bus_wr(2, 8'hD0);
        idle(1);
        check(status == 8'hA0, "R7 rom lock reject", status, 8'hA0);
        wp = 4'b0010;
        bus_wr(0, 8'h20);
        bus_wr(3*BB + 1, 8'hD0);
        bus_wr(0, 8'h20);
        bus_wr(7*BB, 8'hD0);
        idle(1);
        check(status == 8'hA0, "R7 data protect reject", status, 8'hA0);
        mem_cmp("R7 nothing erased");

        // R5 R9: accepted erase clears fail, interrupt on completion
        cur = "R9";
        lock = '0; irq_en = 1'b1;
        bus_wr(0, 8'h20);
        bus_wr(5, 8'hD0);
        check(status == 8'h00, "R5 fail cleared on accept", status, 8'h00);
        irq_seen = 0;
        repeat (BB*CPB + 4) begin @(negedge clk); irq_seen += irq; end
        check(irq_seen == 1, "R9 one pulse", irq_seen, 1);
        mem_cmp("R4 block 0 erased");

        // R8 R10: suspend request without enable, then protection abort
        cur = "R8";
        bus_wr(0, 8'h20);
        bus_wr(4*BB + 7, 8'hD0);
        s_req = 1'b1;
        idle(4);
        check(status[7] == 1'b0, "R10 no pause without enable", status, 8'h00);
        s_req = 1'b0;
        idle(1);
        wp[2] = 1'b1;
        idle(2);
        check(status == 8'hA0, "R8 abort status", status, 8'hA0);
        mem_cmp("R8 partial erase");
        wp = '0;

        // R10 R11 R12: suspend, writes while paused, resume
        cur = "R11";
        s_en = 1'b1;
        bus_wr(0, 8'h20);
        bus_wr(5*BB, 8'hD0);
        idle(3);
        s_req = 1'b1;
        idle(1);
        check(status == 8'h80, "R10 paused ready", status, 8'h80);
        bus_wr(0, 8'h20);
        bus_wr(2*BB, 8'hD0);
        idle(3);
        s_req = 1'b0;
        idle(1);
        check(status[7] == 1'b0, "R11 resumed busy", status, 8'h00);
        bus_wr(0, 8'h20);
        bus_wr(3*BB, 8'hD0);
        busy = 0;
        while (status[7] == 1'b0 && busy < 1000) begin busy++; @(negedge clk); end
        idle(2);
        check(status == 8'h80, "R11 completed", status, 8'h80);
        mem_cmp("R12 only block 5 erased");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule